// File: doc/BRIEF.md
# Rotate, Shift and Bit Manipulation Unit

This is a purely combinational datapath slice for an 8-bit processor core. It takes one operand byte, the current carry flag, a bit index and a four-bit operation code. From these it produces the modified byte and the four condition flags: zero (Z), subtract (N), half-carry (H) and carry (C). It also produces a write enable for the result and one write enable for each flag. The surrounding core uses the enables to decide what to commit to its register file and flag register. Any read-modify-write sequencing of memory operands is left to the core.

The unit covers eight shift-class operations: the four rotates (circular or through carry, in either direction), arithmetic shift left, arithmetic shift right, logical shift right and nibble swap. It also covers three single-bit operations: test, clear and set. A separate select picks a short accumulator form of the four rotates. That form forces Z to zero instead of deriving it from the result. The block has no state, so no operation moves between states. Each output settles within the same cycle as its inputs.

Top module: `rsb_unit`

## Requirements
- R1: Operation code 0 (circular left) returns the operand rotated left by one, with the old bit 7 placed in bit 0, and drives C with the old bit 7.
- R2: Operation code 1 (circular right) returns the operand rotated right by one, with the old bit 0 placed in bit 7, and drives C with the old bit 0.
- R3: Operation code 2 (left through carry) returns {operand[6:0], carry_i} and drives C with the old bit 7. Code 3 (right through carry) returns {carry_i, operand[7:1]} and drives C with the old bit 0.
- R4: Code 4 (arithmetic left) returns {operand[6:0], 0} and drives C with bit 7. Code 5 (arithmetic right) returns {operand[7], operand[7:1]} and drives C with bit 0. Code 7 (logical right) returns {0, operand[7:1]} and drives C with bit 0.
- R5: For codes 0 to 5 and 7 with the accumulator select low, Z is 1 exactly when the result is zero and N = H = 0. All four flag enables are high (flag_we_o = 4'b1111, order Z,N,H,C from bit 3 down) and result_we_o is 1.
- R6: With acc_form_i = 1 and codes 0 to 3, the result and C match R1 to R3, Z = N = H = 0, and all flag and result enables are high. For any other code, acc_form_i has no effect on any output.
- R7: Code 6 (swap) returns {operand[3:0], operand[7:4]}. Z comes from the result, N = H = C = 0, flag_we_o = 4'b1111 and result_we_o = 1.
- R8: Code 8 (test) sets Z to the inverse of operand[bit_idx_i], with N = 0 and H = 1. flag_we_o is 4'b1110, so C is not written and reads 0, and result_we_o is 0.
- R9: Code 9 (clear) and code 10 (set) return the operand with bit bit_idx_i forced to 0 or 1 and every other bit unchanged. result_we_o is 1, flag_we_o is 0 and all flag values read 0.
- R10: Codes 11 to 15 write nothing: result_we_o = 0, flag_we_o = 0, flag values 0 and the result equal to the operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| bit_idx_i | input | 3 | Bit position for codes 8 to 10 |
| carry_i | input | 1 | Current carry flag |
| op_sel_i | input | 4 | Operation code (0 to 10 defined) |
| acc_form_i | input | 1 | Selects the accumulator form of codes 0 to 3 |
| result_o | output | 8 | Modified byte |
| result_we_o | output | 1 | Result write enable |
| flag_z_o | output | 1 | Zero flag value |
| flag_n_o | output | 1 | Subtract flag value |
| flag_h_o | output | 1 | Half-carry flag value |
| flag_c_o | output | 1 | Carry flag value |
| flag_we_o | output | 4 | Flag write enables, bit 3 Z, bit 2 N, bit 1 H, bit 0 C |

## Verification
Every result, flag value and enable depends only on the present inputs, so each one is due in the same cycle that its stimulus is applied, with zero registers on the path. The bench applies a new input vector just after each rising edge and compares all outputs at the following falling edge, half a period later, against a behavioural model built on integer arithmetic. The sweep covers every operation code, both carry values and both accumulator selects across all 256 operands. It also covers all eight bit indices for the three bit operations.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    typedef enum logic [3:0] {
        OP_ROT_LC  = 4'd0,
        OP_ROT_RC  = 4'd1,
        OP_ROT_LT  = 4'd2,
        OP_ROT_RT  = 4'd3,
        OP_SHL_AR  = 4'd4,
        OP_SHR_AR  = 4'd5,
        OP_NIB_SW  = 4'd6,
        OP_SHR_LG  = 4'd7,
        OP_BIT_TST = 4'd8,
        OP_BIT_CLR = 4'd9,
        OP_BIT_SET = 4'd10
    } rsb_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } rsb_flags_t;

    function automatic logic is_rotate(input logic [3:0] op);
        return op <= 4'd3;
    endfunction

    function automatic logic is_bitop(input logic [3:0] op);
        return (op >= 4'd8) && (op <= 4'd10);
    endfunction

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic         cin_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] y_o,
    output logic         cout_o
);
    import rsb_pkg::*;

    localparam int HALF = W / 2;

    always_comb begin
        y_o    = x_i;
        cout_o = 1'b0;
        unique case (op_i)
            OP_ROT_LC: begin
                y_o    = {x_i[W-2:0], x_i[W-1]};
                cout_o = x_i[W-1];
            end
            OP_ROT_RC: begin
                y_o    = {x_i[0], x_i[W-1:1]};
                cout_o = x_i[0];
            end
            OP_ROT_LT: begin
                y_o    = {x_i[W-2:0], cin_i};
                cout_o = x_i[W-1];
            end
            OP_ROT_RT: begin
                y_o    = {cin_i, x_i[W-1:1]};
                cout_o = x_i[0];
            end
            OP_SHL_AR: begin
                y_o    = {x_i[W-2:0], 1'b0};
                cout_o = x_i[W-1];
            end
            OP_SHR_AR: begin
                y_o    = {x_i[W-1], x_i[W-1:1]};
                cout_o = x_i[0];
            end
            OP_NIB_SW: begin
                y_o    = {x_i[HALF-1:0], x_i[W-1:HALF]};
                cout_o = 1'b0;
            end
            OP_SHR_LG: begin
                y_o    = {1'b0, x_i[W-1:1]};
                cout_o = x_i[0];
            end
            default: begin
                y_o    = x_i;
                cout_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     x_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [3:0]       op_i,
    output logic [W-1:0]     y_o,
    output logic             sel_bit_o
);
    import rsb_pkg::*;

    logic [W-1:0] mask;

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign mask[g] = (idx_i == IDX_W'(g));
    end

    assign sel_bit_o = |(x_i & mask);

    always_comb begin
        unique case (op_i)
            OP_BIT_CLR: y_o = x_i & ~mask;
            OP_BIT_SET: y_o = x_i | mask;
            default:    y_o = x_i;
        endcase
    end

    always_comb begin
        a_r9_mask_onehot: assert ($onehot0(mask) && (mask != '0))
            else $error("bit mask not one-hot");
    end

endmodule

// File: rtl/rsb_flagger.sv
module rsb_flagger #(
    parameter int W = 8
) (
    input  logic [3:0]         op_i,
    input  logic               acc_i,
    input  logic [W-1:0]       y_i,
    input  logic               cout_i,
    input  logic               sel_bit_i,
    output rsb_pkg::rsb_flags_t flags_o,
    output rsb_pkg::rsb_flags_t we_o,
    output logic               res_we_o
);
    import rsb_pkg::*;

    logic y_zero;
    assign y_zero = (y_i == '0);

    always_comb begin
        flags_o  = '0;
        we_o     = '0;
        res_we_o = 1'b0;
        unique case (op_i)
            OP_ROT_LC, OP_ROT_RC, OP_ROT_LT, OP_ROT_RT: begin
                flags_o.z = acc_i ? 1'b0 : y_zero;
                flags_o.c = cout_i;
                we_o      = '1;
                res_we_o  = 1'b1;
            end
            OP_SHL_AR, OP_SHR_AR, OP_SHR_LG: begin
                flags_o.z = y_zero;
                flags_o.c = cout_i;
                we_o      = '1;
                res_we_o  = 1'b1;
            end
            OP_NIB_SW: begin
                flags_o.z = y_zero;
                we_o      = '1;
                res_we_o  = 1'b1;
            end
            OP_BIT_TST: begin
                flags_o.z = ~sel_bit_i;
                flags_o.h = 1'b1;
                we_o      = '{z: 1'b1, n: 1'b1, h: 1'b1, c: 1'b0};
            end
            OP_BIT_CLR, OP_BIT_SET: begin
                res_we_o  = 1'b1;
            end
            default: begin
                flags_o  = '0;
                we_o     = '0;
                res_we_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        a_r5_n_never_set: assert (!flags_o.n)
            else $error("N flag set");
    end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [IDX_W-1:0] bit_idx_i,
    input  logic             carry_i,
    input  logic [3:0]       op_sel_i,
    input  logic             acc_form_i,
    output logic [W-1:0]     result_o,
    output logic             result_we_o,
    output logic             flag_z_o,
    output logic             flag_n_o,
    output logic             flag_h_o,
    output logic             flag_c_o,
    output logic [3:0]       flag_we_o
);
    import rsb_pkg::*;

    logic [W-1:0] sh_y;
    logic         sh_cout;
    logic [W-1:0] bo_y;
    logic         bo_sel;
    rsb_flags_t   flg;
    rsb_flags_t   flg_we;
    logic         acc_eff;

    assign acc_eff = acc_form_i & is_rotate(op_sel_i);

    rsb_shifter #(.W(W)) u_shift (
        .x_i    (opnd_i),
        .cin_i  (carry_i),
        .op_i   (op_sel_i),
        .y_o    (sh_y),
        .cout_o (sh_cout)
    );

    rsb_bitop #(.W(W), .IDX_W(IDX_W)) u_bit (
        .x_i       (opnd_i),
        .idx_i     (bit_idx_i),
        .op_i      (op_sel_i),
        .y_o       (bo_y),
        .sel_bit_o (bo_sel)
    );

    rsb_flagger #(.W(W)) u_flag (
        .op_i      (op_sel_i),
        .acc_i     (acc_eff),
        .y_i       (sh_y),
        .cout_i    (sh_cout),
        .sel_bit_i (bo_sel),
        .flags_o   (flg),
        .we_o      (flg_we),
        .res_we_o  (result_we_o)
    );

    assign result_o  = is_bitop(op_sel_i) ? bo_y : sh_y;
    assign flag_z_o  = flg.z;
    assign flag_n_o  = flg.n;
    assign flag_h_o  = flg.h;
    assign flag_c_o  = flg.c;
    assign flag_we_o = flg_we;

    always_comb begin
        if (op_sel_i == OP_BIT_SET || op_sel_i == OP_BIT_CLR) begin
            a_r9_only_index_bit: assert (((result_o ^ opnd_i) & ~(W'(1) << bit_idx_i)) == '0
                                         && result_o[bit_idx_i] == (op_sel_i == OP_BIT_SET)
                                         && flag_we_o == 4'b0000)
                else $error("bit clear/set disturbed other bits or flags");
        end
        if (op_sel_i == OP_BIT_TST) begin
            a_r8_test_no_result: assert (!result_we_o && flag_we_o == 4'b1110
                                         && flag_z_o == !opnd_i[bit_idx_i])
                else $error("bit test wrote result or wrong Z");
        end
        if (acc_form_i && is_rotate(op_sel_i)) begin
            a_r6_acc_z_clear: assert (!flag_z_o)
                else $error("accumulator rotate left Z set");
        end
        if (op_sel_i == OP_SHL_AR) begin
            a_r4_shl_carry: assert (flag_c_o == opnd_i[W-1] && result_o[0] == 1'b0)
                else $error("left shift carry wrong");
        end
        if (op_sel_i > 4'd10) begin
            a_r10_undef_silent: assert (!result_we_o && flag_we_o == 4'b0000
                                        && result_o == opnd_i)
                else $error("undefined code wrote something");
        end
    end

endmodule

// File: tb/sim_rsb_unit.sv
module sim_rsb_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0] opnd;
    logic [2:0] idx;
    logic       cin;
    logic [3:0] op;
    logic       acc;
    logic [7:0] res;
    logic       res_we;
    logic       fz, fn, fh, fc;
    logic [3:0] fwe;

    rsb_unit u0 (
        .opnd_i      (opnd),
        .bit_idx_i   (idx),
        .carry_i     (cin),
        .op_sel_i    (op),
        .acc_form_i  (acc),
        .result_o    (res),
        .result_we_o (res_we),
        .flag_z_o    (fz),
        .flag_n_o    (fn),
        .flag_h_o    (fh),
        .flag_c_o    (fc),
        .flag_we_o   (fwe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    task automatic model(input int o, input int a, input int ci, input int x, input int b,
                         output int y, output int rwe, output int z, output int n,
                         output int h, output int c, output int we, output string tag);
        y = x; rwe = 0; z = 0; n = 0; h = 0; c = 0; we = 0; tag = "R10";
        case (o)
            0: begin y = ((x * 2) + (x / 128)) % 256; c = x / 128;     tag = "R1/R5"; end
            1: begin y = (x / 2) + (x % 2) * 128;     c = x % 2;       tag = "R2/R5"; end
            2: begin y = (x * 2) % 256 + ci;          c = x / 128;     tag = "R3/R5"; end
            3: begin y = (x / 2) + ci * 128;          c = x % 2;       tag = "R3/R5"; end
            4: begin y = (x * 2) % 256;               c = x / 128;     tag = "R4/R5"; end
            5: begin y = (x / 2) + (x / 128) * 128;   c = x % 2;       tag = "R4/R5"; end
            6: begin y = (x % 16) * 16 + (x / 16);    c = 0;           tag = "R7";    end
            7: begin y = x / 2;                       c = x % 2;       tag = "R4/R5"; end
            default: ;
        endcase
        if (o <= 7) begin
            rwe = 1; we = 15;
            z = (y == 0) ? 1 : 0;
            if (o <= 3 && a == 1) begin z = 0; tag = "R6"; end
        end else if (o == 8) begin
            z = (((x >> b) % 2) == 0) ? 1 : 0; h = 1; we = 14; tag = "R8";
        end else if (o == 9 || o == 10) begin
            int bitv;
            bitv = (x >> b) % 2;
            if (o == 9) y = x - bitv * (1 << b);
            else        y = x + (1 - bitv) * (1 << b);
            rwe = 1; tag = "R9";
        end
        if (o > 7 && a == 1) tag = {tag, "+R6"};
    endtask

    task automatic check_now();
        int y, rwe, z, n, h, c, we;
        string tag;
        logic [16:0] got, exp;
        model(int'(op), int'(acc), int'(cin), int'(opnd), int'(idx), y, rwe, z, n, h, c, we, tag);
        got = {res_we, res, fz, fn, fh, fc, fwe};
        exp = {rwe[0], y[7:0], z[0], n[0], h[0], c[0], we[3:0]};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d acc=%0d cin=%0d x=%02h idx=%0d: got %05h expected %05h",
                     tag, op, acc, cin, opnd, idx, got, exp);
        end
    endtask

    task automatic apply(input int o, input int a, input int ci, input int x, input int b);
        @(posedge clk);
        op   = 4'(o);
        acc  = a[0];
        cin  = ci[0];
        opnd = 8'(x);
        idx  = 3'(b);
        @(negedge clk);
        check_now();
    endtask

    initial begin
        op = 4'd0; acc = 1'b0; cin = 1'b0; opnd = 8'h00; idx = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now();              // reset-time output, R1/R5: zero operand gives Z=1
        rst = 1'b0;
        for (int o = 0; o < 16; o++) begin
            for (int a = 0; a < 2; a++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int x = 0; x < 256; x++) begin
                        if (o >= 8 && o <= 10) begin
                            for (int b = 0; b < 8; b++) apply(o, a, ci, x, b);
                        end else begin
                            apply(o, a, ci, x, (x ^ 3) % 8);
                        end
                    end
                end
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired after 200000 cycles");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule